// File: doc/BRIEF.md
# Grouped-Interrupt GPIO Port

A 32-pin general-purpose I/O port controlled through eight 32-bit registers on a simple single-cycle memory-mapped bus. Each pin is an input or a driven output. An output pin can blink, meaning its level flips on a fixed period taken from one shared divider. Every input passes through a two-flop synchronizer and an optional inversion stage. The corrected level is then readable and feeds the interrupt logic.

Interrupt causes come in two kinds. Edge causes latch on a rising edge of the corrected input. Level causes track the corrected input. Two separate mask registers decide which causes count as pending. Pins are collected in groups of eight, and each group has its own active-high interrupt line. Software obtains falling-edge or active-low detection by inverting the pin's input. It acknowledges edge causes by writing zeros to the cause register.

Top module: `gpio_grp_port`

## Requirements
- R1: After synchronous reset every register reads 0 except output-enable control, which reads 0xFFFFFFFF; `pin_oe` is all zero and `grp_irq` is zero.
- R2: An output-enable control bit of 1 makes the pin an input (`pin_oe` bit 0); a bit of 0 sets `pin_oe` to 1 and drives the data-out bit on `pin_out`.
- R3: A pin whose blink bit is set drives data-out XOR a shared phase. The phase flips once every 2^BLINK_BITS clock cycles (default 24) from one free-running counter. Pins whose blink bit is clear drive data-out unchanged.
- R4: The data-in register returns `pin_in` XOR polarity, after a two-flop synchronizer, one bit per pin; writes to it are ignored. Read data appears on `bus_rdata` the cycle after the read strobe.
- R5: An edge cause bit sets on a rising transition of the corrected input, whatever the masks hold, and stays set until cleared.
- R6: Writing the cause register clears every edge-cause bit written as 0 and keeps every bit written as 1; a rising transition in the same cycle wins over the clear.
- R7: For a pin whose level-mask bit is set, the cause read includes the corrected input level, so a clear has no lasting effect while that level stays high.
- R8: The pending vector is cause AND (edge mask OR level mask); `grp_irq[g]` is the OR of pending bits 8g+7..8g.
- R9: Setting a pin's polarity bit makes falling input edges, and low input levels, raise its causes.
- R10: Register byte offsets on `bus_addr`: 0x00 data-out, 0x04 output-enable control, 0x08 blink, 0x0C polarity, 0x10 data-in, 0x14 cause, 0x18 edge mask, 0x1C level mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Output driver enable, 1 = driving |
| grp_irq | output | 4 | Per-group interrupt lines, active high |

## Verification
The input path is tried with a table of input and polarity patterns: all zeros, all ones, alternating bits, single bits, and inversions of the same input. These cases separate a missing or misplaced inversion from a synchronizer fault. Interrupts are tried with patterns that tell an edge cause from a level cause. A rise followed by a fall shows latching. A clear with mixed ones and zeros shows per-bit acknowledge. A clear under a held level shows the level term. An unmasked rise sets its cause but must leave its group line quiet. An inverted pin must respond to the falling edge only. The blink test measures the exact period between phase flips on one pin, while a neighbouring non-blinking pin must hold steady.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
    localparam int NPINS  = 32;
    localparam int GRP_W  = 8;
    localparam int NGRP   = NPINS / GRP_W;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        SEL_DOUT  = 3'd0,
        SEL_OECTL = 3'd1,
        SEL_BLINK = 3'd2,
        SEL_POL   = 3'd3,
        SEL_DIN   = 3'd4,
        SEL_CAUSE = 3'd5,
        SEL_EMASK = 3'd6,
        SEL_LMASK = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] oectl;
        logic [NPINS-1:0] blink;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] emask;
        logic [NPINS-1:0] lmask;
    } cfg_t;

    function automatic reg_sel_e addr_to_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[ADDR_W-1:2]);
    endfunction

    function automatic logic [NPINS-1:0] ack_keep(input logic [NPINS-1:0] held,
                                                  input logic [NPINS-1:0] wmask);
        return held & wmask;
    endfunction
endpackage

// File: rtl/gpio_in_stage.sv
module gpio_in_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_in,
    input  logic [W-1:0] invert,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q, sync_q, level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= '0;
            sync_q  <= '0;
            level_q <= '0;
        end else begin
            meta_q  <= raw_in;
            sync_q  <= meta_q;
            level_q <= level;
        end
    end

    always_comb begin
        level = sync_q ^ invert;
        rise  = level & ~level_q;
    end
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
    parameter int BITS = 24
) (
    input  logic clk,
    input  logic rst,
    output logic phase,
    output logic wrap
);
    logic [BITS-1:0] div_q;

    assign wrap = &div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            phase <= 1'b0;
        end else begin
            div_q <= div_q + 1'b1;
            if (wrap) phase <= ~phase;
        end
    end
endmodule

// File: rtl/gpio_cause_unit.sv
module gpio_cause_unit #(
    parameter int W  = 32,
    parameter int GW = 8,
    localparam int NG = W / GW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  rise,
    input  logic [W-1:0]  level,
    input  logic [W-1:0]  emask,
    input  logic [W-1:0]  lmask,
    input  logic          ack_we,
    input  logic [W-1:0]  ack_data,
    output logic [W-1:0]  edge_q,
    output logic [W-1:0]  cause,
    output logic [NG-1:0] grp_irq
);
    import gpio_grp_pkg::*;

    logic [W-1:0] pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
        end else if (ack_we) begin
            edge_q <= ack_keep(edge_q, ack_data) | rise;
        end else begin
            edge_q <= edge_q | rise;
        end
    end

    always_comb begin
        cause   = edge_q | (level & lmask);
        pending = cause & (emask | lmask);
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_irq[g] = |pending[g*GW +: GW];
    end
endmodule

// File: rtl/gpio_grp_port.sv
module gpio_grp_port #(
    parameter int BLINK_BITS = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe,
    output logic [3:0]  grp_irq
);
    import gpio_grp_pkg::*;

    cfg_t             cfg_q;
    reg_sel_e         sel;
    logic [NPINS-1:0] in_level, rise_vec, edge_latch, cause_vec, mask_any;
    logic             blink_phase, blink_wrap, ack_we;

    assign sel      = addr_to_sel(bus_addr);
    assign ack_we   = bus_we && (sel == SEL_CAUSE);
    assign mask_any = cfg_q.emask | cfg_q.lmask;

    gpio_in_stage #(.W(NPINS)) u_in (
        .clk(clk), .rst(rst), .raw_in(pin_in), .invert(cfg_q.pol),
        .level(in_level), .rise(rise_vec)
    );

    gpio_blink_gen #(.BITS(BLINK_BITS)) u_blink (
        .clk(clk), .rst(rst), .phase(blink_phase), .wrap(blink_wrap)
    );

    gpio_cause_unit #(.W(NPINS), .GW(GRP_W)) u_cause (
        .clk(clk), .rst(rst), .rise(rise_vec), .level(in_level),
        .emask(cfg_q.emask), .lmask(cfg_q.lmask),
        .ack_we(ack_we), .ack_data(bus_wdata),
        .edge_q(edge_latch), .cause(cause_vec), .grp_irq(grp_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= '0;
            cfg_q.oectl <= '1;
        end else if (bus_we) begin
            unique case (sel)
                SEL_DOUT:  cfg_q.dout  <= bus_wdata;
                SEL_OECTL: cfg_q.oectl <= bus_wdata;
                SEL_BLINK: cfg_q.blink <= bus_wdata;
                SEL_POL:   cfg_q.pol   <= bus_wdata;
                SEL_EMASK: cfg_q.emask <= bus_wdata;
                SEL_LMASK: cfg_q.lmask <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            unique case (sel)
                SEL_DOUT:  bus_rdata <= cfg_q.dout;
                SEL_OECTL: bus_rdata <= cfg_q.oectl;
                SEL_BLINK: bus_rdata <= cfg_q.blink;
                SEL_POL:   bus_rdata <= cfg_q.pol;
                SEL_DIN:   bus_rdata <= in_level;
                SEL_CAUSE: bus_rdata <= cause_vec;
                SEL_EMASK: bus_rdata <= cfg_q.emask;
                SEL_LMASK: bus_rdata <= cfg_q.lmask;
                default:   bus_rdata <= '0;
            endcase
        end
    end

    always_comb begin
        pin_out = cfg_q.dout ^ (cfg_q.blink & {NPINS{blink_phase}});
        pin_oe  = ~cfg_q.oectl;
    end
endmodule

// File: rtl/gpio_grp_chk.sv
module gpio_grp_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic [4:0]  bus_addr,
    input logic [31:0] edge_q,
    input logic [31:0] rise,
    input logic [31:0] mask_any,
    input logic        wrap,
    input logic [31:0] pin_out,
    input logic [31:0] pin_oe,
    input logic [3:0]  grp_irq
);
    logic ack;
    assign ack = bus_we && (bus_addr[4:2] == 3'd5);

    AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == 32'h0 && grp_irq == 4'h0)); // R1

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && !wrap) |=> $stable(pin_out)); // R3

    AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((edge_q & $past(rise)) == $past(rise))); // R5

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !ack |=> ((edge_q & $past(edge_q)) == $past(edge_q))); // R6

    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (mask_any == 32'h0) |-> (grp_irq == 4'h0)); // R8
endmodule

bind gpio_grp_port gpio_grp_chk u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .edge_q(edge_latch), .rise(rise_vec), .mask_any(mask_any),
    .wrap(blink_wrap), .pin_out(pin_out), .pin_oe(pin_oe), .grp_irq(grp_irq)
);

// File: tb/gpio_grp_port_test.sv
module gpio_grp_port_test;
    localparam int BB = 4;
    localparam logic [4:0] A_DOUT = 5'h00, A_OE = 5'h04, A_BLK = 5'h08, A_POL = 5'h0C,
                           A_DIN = 5'h10, A_CAU = 5'h14, A_EM = 5'h18, A_LM = 5'h1C;
    // {pin_in, polarity}
    localparam logic [63:0] VECS [0:5] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h0000_0000},
        {32'hA5A5_5A5A, 32'h0000_0000},
        {32'h0000_0000, 32'hFFFF_FFFF},
        {32'h8000_0001, 32'h0F0F_0F0F},
        {32'h1234_5678, 32'h1234_5678}
    };

    logic clk = 0, rst = 1, bus_we = 0, bus_re = 0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
    logic [3:0] grp_irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_grp_port #(.BLINK_BITS(BB)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .grp_irq(grp_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_re = 1; bus_addr = a;
        @(negedge clk); bus_re = 0; d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic ref_bit;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd(A_OE, v);    check("R1 oectl", v, 32'hFFFF_FFFF);
        rd(A_DOUT, v);  check("R1 dout", v, 32'h0);
        rd(A_CAU, v);   check("R1 cause", v, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 grp_irq", {28'h0, grp_irq}, 32'h0);

        // R4 R9 R10 table of input/polarity patterns
        foreach (VECS[i]) begin
            wr(A_POL, VECS[i][31:0]);
            pin_in = VECS[i][63:32];
            settle();
            rd(A_DIN, v);
            check("R4 data-in", v, VECS[i][63:32] ^ VECS[i][31:0]);
        end
        wr(A_DIN, 32'hDEAD_BEEF);
        rd(A_DIN, v); check("R4 data-in write ignored", v, 32'h1234_5678 ^ 32'h1234_5678);
        wr(A_POL, 32'h0); pin_in = 32'h0; settle();
        wr(A_CAU, 32'h0);
        rd(A_CAU, v); check("R6 clear all", v, 32'h0);

        // R2 output drive
        wr(A_OE, 32'hFFFF_0000);
        wr(A_DOUT, 32'h0000_1234);
        check("R2 pin_oe", pin_oe, 32'h0000_FFFF);
        check("R2 pin_out", pin_out, 32'h0000_1234);

        // R5 R8 edge cause on pin 9, group 1
        wr(A_EM, 32'h0000_0200);
        pin_in[9] = 1; settle();
        rd(A_CAU, v); check("R5 edge set", v, 32'h0000_0200);
        check("R8 group1 irq", {28'h0, grp_irq}, 32'h2);
        pin_in[9] = 0; settle();
        rd(A_CAU, v); check("R5 edge sticky", v, 32'h0000_0200);
        wr(A_CAU, ~32'h0000_0200);
        rd(A_CAU, v); check("R6 clear by zero", v, 32'h0);
        check("R8 irq drops", {28'h0, grp_irq}, 32'h0);

        // R5 R6 R8 unmasked causes and write-one keeps
        wr(A_EM, 32'h0);
        pin_in[1] = 1; pin_in[20] = 1; settle();
        rd(A_CAU, v); check("R5 cause without mask", v, 32'h0010_0002);
        check("R8 masked off no irq", {28'h0, grp_irq}, 32'h0);
        wr(A_CAU, 32'h0000_0002);
        rd(A_CAU, v); check("R6 one keeps zero clears", v, 32'h0000_0002);
        pin_in[1] = 0; pin_in[20] = 0; settle();
        wr(A_CAU, 32'h0);

        // R7 level cause on pin 26, group 3
        wr(A_LM, 32'h0400_0000);
        pin_in[26] = 1; settle();
        check("R7 level irq", {28'h0, grp_irq}, 32'h8);
        wr(A_CAU, 32'h0);
        rd(A_CAU, v); check("R7 clear under level", v, 32'h0400_0000);
        check("R7 irq held", {28'h0, grp_irq}, 32'h8);
        pin_in[26] = 0; settle();
        rd(A_CAU, v); check("R7 level gone", v, 32'h0);
        check("R7 irq gone", {28'h0, grp_irq}, 32'h0);
        wr(A_LM, 32'h0);

        // R9 falling edge via polarity on pin 3
        wr(A_EM, 32'h0000_0008);
        wr(A_POL, 32'h0000_0008); settle();
        wr(A_CAU, 32'h0);
        pin_in[3] = 1; settle();
        rd(A_CAU, v); check("R9 rise ignored when inverted", v, 32'h0);
        pin_in[3] = 0; settle();
        rd(A_CAU, v); check("R9 fall raises cause", v, 32'h0000_0008);
        check("R9 group0 irq", {28'h0, grp_irq}, 32'h1);
        rd(A_DIN, v); check("R9 data-in inverted", v, 32'h0000_0008);
        wr(A_POL, 32'h0); wr(A_EM, 32'h0); wr(A_CAU, 32'h0);

        // R3 blink on pin 5, pin 4 steady
        wr(A_BLK, 32'h0000_0020);
        ref_bit = pin_out[5];
        for (int k = 0; k < 40 && pin_out[5] == ref_bit; k++) @(negedge clk);
        ref_bit = pin_out[5];
        for (int k = 1; k <= (1 << BB); k++) begin
            @(negedge clk);
            if (k < (1 << BB)) begin
                if (pin_out[5] != ref_bit) check("R3 blink held", {31'h0, pin_out[5]}, {31'h0, ref_bit});
            end else begin
                check("R3 blink period", {31'h0, pin_out[5]}, {31'h0, ~ref_bit});
            end
        end
        check("R3 non-blink pin steady", {31'h0, pin_out[4]}, 32'h1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule